// File: doc/BRIEF.md
# Edge-Sensing GPIO Port with Maskable Interrupt

This block is a 32-pin general-purpose I/O port controlled through six word-wide registers on a simple register bus. Each pin can be an output or an input. Output pins follow the stored data word. Input pins are passed through a two-flop synchroniser and copied into that same data word. Every change that qualifies on an input pin latches a per-pin event flag. A single level interrupt is raised while any flagged event is also enabled in the mask word.

Software selects a pin's role with the direction word: a 1 makes the pin an output. The edge-sense word picks how each input pin captures events: a 0 captures both edges, a 1 captures only high-to-low transitions. Event flags are cleared by writing ones to them. The open-drain word has no internal effect; it is stored and presented per pin so that pad logic can use it.

Pins are numbered from the most significant end: pin i lives at register bit 31-i. Reads are combinational. Register updates occur on the rising clock edge after a write cycle.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, all six registers read 0, `irq` is low, and `pin_out`, `pin_oe` and `pin_od` are all 0.
- R2: Registers are decoded at byte offsets 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 mask and 0x14 edge-sense. Direction, open-drain, mask and edge-sense read back what was written. Any other offset reads 0.
- R3: Only accesses with `bus_size` = 4 (bytes) are honoured. A read with any other size returns 0, and a write with any other size leaves every register unchanged.
- R4: Pin i corresponds to register bit 31-i in every register. `pin_oe[i]` equals direction bit 31-i, and `pin_od[i]` equals open-drain bit 31-i.
- R5: `pin_out[i]` equals data bit 31-i when direction bit 31-i is 1, and is 0 otherwise. A data write stores all 32 written bits.
- R6: An input pin (direction bit 0) copies its synchronised level into its data bit whenever that level changes. A pin whose direction bit is 1 ignores its input: the data bit does not change and no event is latched.
- R7: With its edge-sense bit at 0, an input pin latches its event bit on both a rising and a falling transition.
- R8: With its edge-sense bit at 1, an input pin latches its event bit only on a falling transition. A rising transition still updates the data bit.
- R9: A write to the event register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R10: `irq` is high exactly when the AND of the event and mask registers is nonzero. It follows register changes on the same clock edge that updates them.
- R11: If a qualifying pin transition and a clearing write hit the same event bit on the same clock edge, the bit stays set.
- R12: A pin transition that is stable on `pin_in` appears in the data register after exactly three rising clock edges: two synchroniser stages and one compare stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_size | input | 3 | Access size in bytes; only 4 is honoured |
| bus_we | input | 1 | Write strobe, committed on the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_in | input | 32 | Pad input levels, index = pin number |
| pin_out | output | 32 | Pad output levels, index = pin number |
| pin_oe | output | 32 | Per-pin output enable (direction) |
| pin_od | output | 32 | Per-pin open-drain qualifier |
| irq | output | 1 | Level interrupt: pending and enabled event |

## Verification
The hardest case to create is a clearing write and a new edge landing on the same event bit at the same clock edge. The bench gets there by counting the three-stage input latency. It changes the pin on one falling edge and then drives the clearing write two falling edges later, so that both commit on the third rising edge. Falling-only capture is also exercised in full: every pin is swept through both edge-sense settings and both transition directions, with the expected data and event words computed from the pin index.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int ADDR_W    = 8;
    localparam int SIZE_W    = 3;
    localparam logic [SIZE_W-1:0] FULL_WORD = 3'd4;

    localparam logic [ADDR_W-1:0] OFS_DIR = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_ODR = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EVT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MSK = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_SNS = 8'h14;

    typedef enum logic [2:0] {
        SEL_DIR,
        SEL_ODR,
        SEL_DAT,
        SEL_EVT,
        SEL_MSK,
        SEL_SNS,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        unique case (a)
            OFS_DIR: decode_ofs = SEL_DIR;
            OFS_ODR: decode_ofs = SEL_ODR;
            OFS_DAT: decode_ofs = SEL_DAT;
            OFS_EVT: decode_ofs = SEL_EVT;
            OFS_MSK: decode_ofs = SEL_MSK;
            OFS_SNS: decode_ofs = SEL_SNS;
            default: decode_ofs = SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            synced <= '0;
        end else begin
            stage1 <= raw;
            synced <= stage1;
        end
    end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,        // synchronised level, register-bit order
    input  logic [W-1:0] is_input,   // 1 where direction bit is 0
    input  logic [W-1:0] fall_only,  // edge-sense word
    output logic [W-1:0] chg,        // input pin changed level
    output logic [W-1:0] hit         // qualifying event
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic moved, dropped;
        assign moved    = prev[g] ^ lvl[g];
        assign dropped  = prev[g] & ~lvl[g];
        assign chg[g]   = is_input[g] & moved;
        assign hit[g]   = is_input[g] & (fall_only[g] ? dropped : moved);
    end

    AST_HIT_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~chg) == '0); // R8
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
    import gpio_edge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    input  logic              we,
    input  logic [W-1:0]      dir_q,
    input  logic [W-1:0]      odr_q,
    input  logic [W-1:0]      dat_q,
    input  logic [W-1:0]      evt_q,
    input  logic [W-1:0]      msk_q,
    input  logic [W-1:0]      sns_q,
    output reg_sel_e          sel,
    output logic              wr_en,
    output logic [W-1:0]      rdata
);
    logic full;

    assign full  = (size == FULL_WORD);
    assign sel   = decode_ofs(addr);
    assign wr_en = we & full;

    always_comb begin
        rdata = '0;
        if (full) begin
            unique case (sel)
                SEL_DIR:  rdata = dir_q;
                SEL_ODR:  rdata = odr_q;
                SEL_DAT:  rdata = dat_q;
                SEL_EVT:  rdata = evt_q;
                SEL_MSK:  rdata = msk_q;
                SEL_SNS:  rdata = sns_q;
                default:  rdata = '0;
            endcase
        end
    end

    AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (size != FULL_WORD) |-> (rdata == '0)); // R3
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_edge_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  reg_sel_e     sel,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] chg,
    input  logic [W-1:0] hit,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] odr_q,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] evt_q,
    output logic [W-1:0] msk_q,
    output logic [W-1:0] sns_q
);
    logic         wr_dir, wr_odr, wr_dat, wr_evt, wr_msk, wr_sns;
    logic [W-1:0] dat_sw, dat_d, evt_d;

    assign wr_dir = wr_en && (sel == SEL_DIR);
    assign wr_odr = wr_en && (sel == SEL_ODR);
    assign wr_dat = wr_en && (sel == SEL_DAT);
    assign wr_evt = wr_en && (sel == SEL_EVT);
    assign wr_msk = wr_en && (sel == SEL_MSK);
    assign wr_sns = wr_en && (sel == SEL_SNS);

    always_comb begin
        dat_sw = wr_dat ? wdata : dat_q;
        dat_d  = (dat_sw & ~chg) | (lvl & chg);
        evt_d  = (wr_evt ? (evt_q & ~wdata) : evt_q) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            odr_q <= '0;
            dat_q <= '0;
            evt_q <= '0;
            msk_q <= '0;
            sns_q <= '0;
        end else begin
            if (wr_dir) dir_q <= wdata;
            if (wr_odr) odr_q <= wdata;
            if (wr_msk) msk_q <= wdata;
            if (wr_sns) sns_q <= wdata;
            dat_q <= dat_d;
            evt_q <= evt_d;
        end
    end

    AST_EVENT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_q & ~$past(evt_q)) & ~$past(hit)) == '0); // R7

    AST_CLEAR_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_evt) |-> ((evt_q & $past(wdata) & ~$past(hit)) == '0)); // R9

    AST_HIT_KEEPS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ((~evt_q) & $past(hit)) == '0); // R11

    AST_OUTPUT_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_dat) |-> (((dat_q ^ $past(dat_q)) & $past(dir_q)) == '0)); // R6
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic              bus_we,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_od,
    output logic              irq
);
    localparam int TOP = NPINS - 1;

    logic [NPINS-1:0] in_regord, lvl, chg, hit;
    logic [NPINS-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, sns_q;
    reg_sel_e         sel;
    logic             wr_en;

    // pin i sits at register bit TOP-i
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign in_regord[TOP-p] = pin_in[p];
        assign pin_oe[p]        = dir_q[TOP-p];
        assign pin_od[p]        = odr_q[TOP-p];
        assign pin_out[p]       = dir_q[TOP-p] & dat_q[TOP-p];
    end

    gpio_pin_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (in_regord),
        .synced (lvl)
    );

    gpio_edge_detect #(.W(NPINS)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .lvl       (lvl),
        .is_input  (~dir_q),
        .fall_only (sns_q),
        .chg       (chg),
        .hit       (hit)
    );

    gpio_bus_port #(.W(NPINS)) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .size  (bus_size),
        .we    (bus_we),
        .dir_q (dir_q),
        .odr_q (odr_q),
        .dat_q (dat_q),
        .evt_q (evt_q),
        .msk_q (msk_q),
        .sns_q (sns_q),
        .sel   (sel),
        .wr_en (wr_en),
        .rdata (bus_rdata)
    );

    gpio_regbank #(.W(NPINS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .wr_en (wr_en),
        .wdata (bus_wdata),
        .lvl   (lvl),
        .chg   (chg),
        .hit   (hit),
        .dir_q (dir_q),
        .odr_q (odr_q),
        .dat_q (dat_q),
        .evt_q (evt_q),
        .msk_q (msk_q),
        .sns_q (sns_q)
    );

    assign irq = |(evt_q & msk_q);

    AST_NARROW_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && (bus_size != FULL_WORD)) |->
        ($stable(pin_oe) && $stable(pin_od))); // R3

    AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit) != '0 || $past(wr_en))); // R10
endmodule

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [2:0]  bus_size = 3'd4;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe, pin_od;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    gpio_edge_port u_gpio_edge_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_od(pin_od),
        .irq(irq)
    );

    localparam logic [7:0] A_DIR = 8'h00, A_ODR = 8'h04, A_DAT = 8'h08,
                           A_EVT = 8'h0C, A_MSK = 8'h10, A_SNS = 8'h14;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_size = sz; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_size = 3'd4;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd4);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_we = 1'b0;
        #1 d = bus_rdata;
        bus_size = 3'd4;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 dir", A_DIR, 0); rd_chk("R1 odr", A_ODR, 0);
        rd_chk("R1 dat", A_DAT, 0); rd_chk("R1 evt", A_EVT, 0);
        rd_chk("R1 msk", A_MSK, 0); rd_chk("R1 sns", A_SNS, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 pin_out", pin_out, 0); check("R1 pin_oe", pin_oe, 0);
        check("R1 pin_od", pin_od, 0);

        // R2 decode and readback
        wr(A_DIR, 32'hA5A5_0F0F); rd_chk("R2 dir", A_DIR, 32'hA5A5_0F0F);
        wr(A_ODR, 32'h1234_5678); rd_chk("R2 odr", A_ODR, 32'h1234_5678);
        wr(A_MSK, 32'hCAFE_0001); rd_chk("R2 msk", A_MSK, 32'hCAFE_0001);
        wr(A_SNS, 32'h8000_FFFF); rd_chk("R2 sns", A_SNS, 32'h8000_FFFF);
        rd_chk("R2 unmapped 18", 8'h18, 0); rd_chk("R2 unmapped 02", 8'h02, 0);
        rd_chk("R2 unmapped FC", 8'hFC, 0);
        wr(A_DIR, 0); wr(A_ODR, 0); wr(A_MSK, 0); wr(A_SNS, 0);

        // R3 narrow accesses
        wr(A_DIR, 32'hFFFF_FFFF, 3'd2); rd_chk("R3 narrow write dir", A_DIR, 0);
        wr(A_MSK, 32'hFFFF_FFFF, 3'd1); rd_chk("R3 narrow write msk", A_MSK, 0);
        wr(A_DIR, 32'h0000_00FF);
        rd(A_DIR, v, 3'd1); check("R3 narrow read", v, 0);
        rd(A_DIR, v, 3'd2); check("R3 half read", v, 0);
        rd_chk("R3 full read", A_DIR, 32'h0000_00FF);
        wr(A_DIR, 0);

        // R4/R5 output mapping sweep
        for (int i = 0; i < 32; i++) begin
            logic [31:0] rb, pv;
            rb = 32'h8000_0000 >> i; pv = 32'h1 << i;
            wr(A_DIR, rb); wr(A_ODR, rb); wr(A_DAT, 32'hFFFF_FFFF);
            @(negedge clk);
            check("R4 pin_oe", pin_oe, pv);
            check("R4 pin_od", pin_od, pv);
            check("R5 pin_out high", pin_out, pv);
            wr(A_DAT, ~rb);
            @(negedge clk);
            check("R5 pin_out low", pin_out, 0);
            rd_chk("R5 dat stores all bits", A_DAT, ~rb);
        end
        wr(A_DIR, 0); wr(A_ODR, 0); wr(A_DAT, 0);

        // R6/R7/R8 input sweep, every pin, both edge-sense settings
        wr(A_MSK, 32'hFFFF_FFFF);
        for (int i = 0; i < 32; i++) begin
            logic [31:0] rb, pv;
            rb = 32'h8000_0000 >> i; pv = 32'h1 << i;
            wr(A_SNS, 0); wr(A_EVT, 32'hFFFF_FFFF);
            @(negedge clk) pin_in = pv; settle();
            rd_chk("R6 dat follows rise", A_DAT, rb);
            rd_chk("R7 rise event", A_EVT, rb);
            check("R10 irq set", {31'b0, irq}, 1);
            wr(A_EVT, rb); rd_chk("R9 cleared", A_EVT, 0);
            check("R10 irq clear", {31'b0, irq}, 0);
            @(negedge clk) pin_in = 0; settle();
            rd_chk("R7 fall event", A_EVT, rb);
            wr(A_EVT, rb); wr(A_SNS, rb);
            @(negedge clk) pin_in = pv; settle();
            rd_chk("R8 rise updates dat", A_DAT, rb);
            rd_chk("R8 rise no event", A_EVT, 0);
            @(negedge clk) pin_in = 0; settle();
            rd_chk("R8 fall dat", A_DAT, 0);
            rd_chk("R8 fall event", A_EVT, rb);
        end
        wr(A_EVT, 32'hFFFF_FFFF); wr(A_SNS, 0); wr(A_MSK, 0);

        // R6 output pins ignore inputs
        wr(A_DIR, 32'hFFFF_FFFF); wr(A_DAT, 32'h0F0F_0F0F);
        @(negedge clk) pin_in = 32'hFFFF_FFFF; settle();
        rd_chk("R6 output ignores in dat", A_DAT, 32'h0F0F_0F0F);
        rd_chk("R6 output ignores in evt", A_EVT, 0);
        @(negedge clk) pin_in = 0; settle();
        rd_chk("R6 output ignores fall", A_EVT, 0);
        wr(A_DIR, 0); wr(A_DAT, 0);

        // R12 latency: pin 3 -> bit 28
        @(negedge clk);
        bus_addr = A_DAT; pin_in = 32'h8;
        @(negedge clk); @(negedge clk);
        check("R12 two edges old", bus_rdata, 0);
        @(negedge clk);
        check("R12 third edge new", bus_rdata, 32'h1000_0000);
        @(negedge clk) pin_in = 0; settle();
        wr(A_EVT, 32'hFFFF_FFFF);

        // R10 masking
        @(negedge clk) pin_in = 32'h20; settle();        // pin 5 -> bit 26
        rd_chk("R10 evt pending", A_EVT, 32'h0400_0000);
        check("R10 masked low", {31'b0, irq}, 0);
        wr(A_MSK, 32'h0400_0000); @(negedge clk);
        check("R10 enabled high", {31'b0, irq}, 1);
        wr(A_MSK, 32'h0200_0000); @(negedge clk);
        check("R10 other bit low", {31'b0, irq}, 0);

        // R9 partial clear: pin 6 -> bit 25 also pending
        @(negedge clk) pin_in = 32'h60; settle();
        rd_chk("R9 two pending", A_EVT, 32'h0600_0000);
        wr(A_EVT, 32'h0400_0000);
        rd_chk("R9 one cleared", A_EVT, 32'h0200_0000);
        wr(A_EVT, 32'hFFFF_FFFF); wr(A_MSK, 0);

        // R11 clear and edge on the same edge (pin 5 falls, bit 26)
        @(negedge clk) pin_in = 32'h40;                    // t0
        @(negedge clk);                                     // after edge 1
        @(negedge clk);                                     // after edge 2
        bus_addr = A_EVT; bus_wdata = 32'h0400_0000; bus_we = 1'b1;
        @(negedge clk) bus_we = 1'b0;                       // edge 3 commits both
        rd_chk("R11 event wins", A_EVT, 32'h0400_0000);
        wr(A_EVT, 32'h0400_0000);
        rd_chk("R11 later clear", A_EVT, 0);

        finish_run();
    end
endmodule